// File: doc/BRIEF.md
# Security-partitioned GPIO register access filter

This block is the register front end of a multi-group GPIO controller. Every I/O line carries one attribute bit that marks it as secure or non-secure. The block holds these attribute bits, together with a per-line output data register. It also decodes a simple memory-mapped port that carries address, write data, write and read strobes and a sideband flag. That flag says whether the requesting host is secure.

The address space is split into two aliased windows. The lower window, below offset 0x1000, may be used by any host and reaches only non-secure lines. The upper window, from 0x1000 upward, reaches only secure lines and only when the host is secure. Inside either window, every per-line write is masked so that lines of the other class keep their value. Every per-line read returns 0 in the bits that belong to the other class. The attribute bits can only be changed through the upper window.

Top module: `gpio_sec_filter`

## Requirements
- R1: After reset every line is secure and every output bit is 0, so a status read through the upper window returns 0 and `rdata` is 0.
- R2: Address bit 12 selects the window (1 = secure window), bits 11:6 select the group (0x40 per group), and bits 5:0 select the register: 0x00 data, 0x04 bit-set, 0x08 bit-clear, 0x30 make-non-secure, 0x34 make-secure, 0x38 security status. For example, group 2 make-non-secure sits at 0x10B0 and group 1 make-secure at 0x1074.
- R3: Writing through the secure window makes a line non-secure for each 1 bit written to make-non-secure, and secure for each 1 bit written to make-secure. Bits written as 0 leave their lines unchanged. Writes to these two offsets through the non-secure window change nothing.
- R4: A status read through the secure window returns 1 for each non-secure line and 0 for each secure line. The same offset read through the non-secure window returns 0.
- R5: A data write updates only the lines whose class matches the window. All other lines of the group keep their output value.
- R6: A data read returns the output value of the lines that match the window and 0 in all other bits.
- R7: A 1 bit written to bit-set drives a matching line to 1, and a 1 bit written to bit-clear drives it to 0. Bits written as 0, and lines of the other class, are unchanged.
- R8: When a non-secure host uses the secure window, the access is ignored and the read returns 0. No error is signalled.
- R9: Undefined offsets, groups at or beyond the group count, and the write-only offsets (0x04, 0x08, 0x30, 0x34) all read as 0. Writes to undefined offsets or groups change nothing.
- R10: Read data appears on `rdata` in the cycle after `rd` is asserted, and `rdata` is 0 in any cycle that follows a cycle without `rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | Byte address: window, group and register |
| wdata | input | 32 | Write data, one bit per line |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| host_sec | input | 1 | High when the requesting host is secure |
| rdata | output | 32 | Registered read data |
| pio_out | output | 128 | Output value of every line, group 0 in the low bits |

## Verification
The hardest case to reach is a group that holds a mix of secure and non-secure lines while writes arrive through both windows and from both kinds of host. Only in that case does a wrong mask show up as a corrupted neighbour bit. The stimulus first splits the classes with directed attribute writes, including the 0x10B0 example. It then runs a long random mix of windows, host flags, offsets and group indices, some of them out of range. A behavioural model compares `pio_out` and `rdata` against the design on every cycle.

// File: rtl/gpio_sec_filter.sv
module gpio_sec_filter #(
  parameter int NGROUPS = 4,
  parameter int LINES   = 32,
  parameter int AW      = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              addr,
  input  logic [LINES-1:0]           wdata,
  input  logic                       wr,
  input  logic                       rd,
  input  logic                       host_sec,
  output logic [LINES-1:0]           rdata,
  output logic [NGROUPS*LINES-1:0]   pio_out
);

  localparam int GSEL_W = AW - 7;
  localparam int GI_W   = (NGROUPS > 1) ? $clog2(NGROUPS) : 1;
  localparam logic [GSEL_W-1:0] NG_L = GSEL_W'(NGROUPS);
  localparam logic [5:0] OFF_DATA = 6'h00;
  localparam logic [5:0] OFF_SET  = 6'h04;
  localparam logic [5:0] OFF_CLR  = 6'h08;
  localparam logic [5:0] OFF_MKNS = 6'h30;
  localparam logic [5:0] OFF_MKS  = 6'h34;
  localparam logic [5:0] OFF_STAT = 6'h38;

  logic [LINES-1:0] ns_q  [NGROUPS];
  logic [LINES-1:0] out_q [NGROUPS];
  logic [NGROUPS*LINES-1:0] ns_flat;

  logic              win_sec, grp_ok, live;
  logic [GSEL_W-1:0] gsel;
  logic [GI_W-1:0]   gi;
  logic [5:0]        off;
  logic [LINES-1:0]  cur_ns, cur_out, mask, wmask, rd_val;

  assign win_sec = addr[AW-1];
  assign gsel    = addr[AW-2:6];
  assign off     = addr[5:0];
  assign grp_ok  = gsel < NG_L;
  assign gi      = gsel[GI_W-1:0];
  assign live    = grp_ok && (!win_sec || host_sec);
  assign cur_ns  = ns_q[gi];
  assign cur_out = out_q[gi];
  assign mask    = win_sec ? ~cur_ns : cur_ns;
  assign wmask   = mask & wdata;

  always_comb begin
    rd_val = '0;
    if (rd && live) begin
      if (off == OFF_DATA) rd_val = cur_out & mask;
      else if (off == OFF_STAT && win_sec) rd_val = cur_ns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGROUPS; g++) begin
        ns_q[g]  <= '0;
        out_q[g] <= '0;
      end
      rdata <= '0;
    end else begin
      rdata <= rd_val;
      if (wr && live) begin
        case (off)
          OFF_DATA: out_q[gi] <= (cur_out & ~mask) | wmask;
          OFF_SET:  out_q[gi] <= cur_out | wmask;
          OFF_CLR:  out_q[gi] <= cur_out & ~wmask;
          OFF_MKNS: if (win_sec) ns_q[gi] <= cur_ns | wdata;
          OFF_MKS:  if (win_sec) ns_q[gi] <= cur_ns & ~wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_flat
    assign pio_out[g*LINES +: LINES] = out_q[g];
    assign ns_flat[g*LINES +: LINES] = ns_q[g];
  end

  AST_NS_WIN_KEEPS_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !win_sec) |=> $stable(ns_flat)); // R3
  AST_NS_WIN_KEEPS_SECURE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !win_sec) |=> ((pio_out ^ $past(pio_out)) & ~$past(ns_flat)) == '0); // R5
  AST_SEC_WIN_KEEPS_NS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win_sec) |=> ((pio_out ^ $past(pio_out)) & $past(ns_flat)) == '0); // R5
  AST_DENIED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win_sec && !host_sec) |=> ($stable(pio_out) && $stable(ns_flat))); // R8
  AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && win_sec && !host_sec) |=> rdata == '0); // R8
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == '0); // R10
  AST_BAD_GROUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !grp_ok) |=> ($stable(pio_out) && $stable(ns_flat))); // R9

endmodule

// File: tb/gpio_sec_filter_tb.sv
module gpio_sec_filter_tb_top;
  localparam int NG = 4;
  localparam int L  = 32;

  logic clk = 0, rst_n = 0;
  logic [12:0] addr = '0;
  logic [L-1:0] wdata = '0;
  logic wr = 0, rd = 0, host_sec = 0;
  logic [L-1:0] rdata;
  logic [NG*L-1:0] pio_out;

  int checks = 0, fails = 0;
  bit done = 0;

  bit [L-1:0] m_ns [NG];
  bit [L-1:0] m_out [NG];
  bit [L-1:0] m_rd;

  gpio_sec_filter dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .host_sec(host_sec), .rdata(rdata), .pio_out(pio_out));

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(bit w, bit r, bit [12:0] a, bit [L-1:0] d, bit hs);
    int g = int'(a[11:6]);
    int o = int'(a[5:0]);
    bit sw = a[12];
    m_rd = '0;
    if (g < NG && (!sw || hs)) begin
      for (int i = 0; i < L; i++) begin
        bit mine = sw ? !m_ns[g][i] : m_ns[g][i];
        if (r && o == 0 && mine) m_rd[i] = m_out[g][i];
        if (r && o == 56 && sw) m_rd[i] = m_ns[g][i];
      end
      if (w) for (int i = 0; i < L; i++) begin
        bit mine = sw ? !m_ns[g][i] : m_ns[g][i];
        case (o)
          0:  if (mine) m_out[g][i] = d[i];
          4:  if (mine && d[i]) m_out[g][i] = 1'b1;
          8:  if (mine && d[i]) m_out[g][i] = 1'b0;
          48: if (sw && d[i]) m_ns[g][i] = 1'b1;
          52: if (sw && d[i]) m_ns[g][i] = 1'b0;
          default: ;
        endcase
      end
    end
  endtask

  function automatic logic [127:0] model_pio();
    logic [127:0] v;
    for (int g = 0; g < NG; g++) v[g*L +: L] = m_out[g];
    return v;
  endfunction

  task automatic op(bit w, bit r, bit [12:0] a, bit [L-1:0] d, bit hs, string tag);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; host_sec = hs;
    @(posedge clk);
    model_step(w, r, a, d, hs);
    @(negedge clk);
    wr = 0; rd = 0;
    chk({tag, " pio_out"}, 128'(pio_out), model_pio());
    chk({tag, " rdata"}, 128'(rdata), 128'(m_rd));
  endtask

  function automatic string tag_of(int o, bit sw, bit hs, int g);
    if (g >= NG) return "R9";
    if (sw && !hs) return "R8";
    case (o)
      0: return "R5";
      4, 8: return "R7";
      48, 52: return "R3";
      56: return "R4";
      default: return "R9";
    endcase
  endfunction

  initial begin
    for (int g = 0; g < NG; g++) begin m_ns[g] = '0; m_out[g] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pio_out", 128'(pio_out), 128'h0);
    chk("R1 reset rdata", 128'(rdata), 128'h0);
    op(0, 1, 13'h1038, 0, 1, "R1 status after reset");
    chk("R1 status zero", 128'(rdata), 128'h0);
    op(1, 0, 13'h1000, 32'hFFFF_FFFF, 1, "R5 secure window fill g0");
    chk("R5 all secure lines written", 128'(pio_out[31:0]), 128'hFFFF_FFFF);
    op(0, 1, 13'h0000, 0, 0, "R6 ns window read of secure lines");
    chk("R6 zero for other class", 128'(rdata), 128'h0);
    op(1, 0, 13'h1030, 32'h0000_00FF, 1, "R3 make low byte non-secure");
    op(1, 0, 13'h10B0, 32'h0000_0010, 1, "R2 g2 make-nonsecure at 0x10B0");
    op(0, 1, 13'h1038, 0, 1, "R4 status g0");
    chk("R4 status value", 128'(rdata), 128'h0000_00FF);
    op(0, 1, 13'h10B8, 0, 1, "R2 status g2");
    chk("R2 g2 line 4 non-secure", 128'(rdata), 128'h0000_0010);
    op(0, 1, 13'h0038, 0, 0, "R4 status via ns window");
    chk("R4 ns window status zero", 128'(rdata), 128'h0);
    op(1, 0, 13'h0000, 32'h0, 0, "R5 ns window clear");
    chk("R5 only ns lines cleared", 128'(pio_out[31:0]), 128'hFFFF_FF00);
    op(1, 0, 13'h0034, 32'hFFFF_FFFF, 0, "R3 make-secure via ns window ignored");
    op(0, 1, 13'h1038, 0, 1, "R3 status unchanged");
    chk("R3 attr kept", 128'(rdata), 128'h0000_00FF);
    op(1, 0, 13'h1074, 32'h0000_0001, 1, "R2 g1 make-secure at 0x1074");
    op(1, 0, 13'h1000, 32'h0, 0, "R8 denied write");
    op(0, 1, 13'h1000, 0, 0, "R8 denied read");
    chk("R8 denied read zero", 128'(rdata), 128'h0);
    op(1, 0, 13'h0004, 32'h0000_0F0F, 0, "R7 set via ns window");
    chk("R7 set only ns bits", 128'(pio_out[31:0]), 128'hFFFF_FF0F);
    op(1, 0, 13'h1008, 32'h0000_F0F0, 1, "R7 clear via secure window");
    chk("R7 clear only secure bits", 128'(pio_out[31:0]), 128'hFFFF_0F0F);
    op(0, 1, 13'h1004, 0, 1, "R9 write-only offset reads zero");
    op(1, 1, 13'h100C, 32'hFFFF_FFFF, 1, "R9 undefined offset");
    op(1, 1, 13'h1140, 32'hFFFF_FFFF, 1, "R9 group beyond count");
    op(0, 0, 13'h1000, 0, 1, "R10 no read gives zero");
    chk("R10 idle rdata", 128'(rdata), 128'h0);
    for (int n = 0; n < 600; n++) begin
      int offs[8] = '{0, 4, 8, 48, 52, 56, 12, 60};
      int g = int'($urandom_range(0, 5));
      int o = offs[$urandom_range(0, 7)];
      bit sw = 1'($urandom_range(0, 1));
      bit hs = 1'($urandom_range(0, 1));
      bit [12:0] a = {sw, 6'(g), 6'(o)};
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom, hs, tag_of(o, sw, hs, g));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule